// File: doc/BRIEF.md
# PCIe Configuration Window Address Translator

This block sits between a memory-mapped slave bus and the configuration-request address port of a PCIe core. Software reaches configuration space by accessing a 64 KB window whose position in the address map is set by a programmable base register. The lower 32 KB of the window is divided into eight 4 KB regions. Each region has its own 16-bit bus/device/function (BDF) register, and software loads these registers through a separate control port.

For every slave access that falls inside the lower half of the window, the block builds the core-side address word from three parts: the region's BDF register, zeros, and the register offset inside the region. It also sets a request-type flag. Region 0 always produces type 0 requests. The other seven regions always produce type 1 requests. Request, direction, byte enables, write data and the ready/read-data return all pass through combinationally.

An access anywhere else is not forwarded to the core. It is completed in the same cycle with a decode-error response. Control-port writes take effect on the next clock edge.

Top module: `cfgwin_xlate`

## Requirements
- R1: For a forwarded access, the core address is {BDF[15:0], 4'b0000, slave address bits 11:2, 2'b00}. Bits 15:12 and 1:0 are always zero.
- R2: Slave address bits 14:12 (window offset bits 15:12, where bit 15 is zero inside the lower half) choose which of BDF registers 0..7 supplies the upper 16 bits.
- R3: `cType1` is 0 when window offset bits 15:12 are all zero and 1 otherwise, so region 0 only ever issues type 0 requests.
- R4: An access hits when slave address bits 31:16 equal the base register and bit 15 is 0. On a hit, `cReq` follows `sReq`, `sReady` follows `cReady`, `sRData` follows `cRData`, and `sResp` is 2'b00 (okay). With `sReq` low, `cReq` is low.
- R5: An access that misses keeps `cReq` low. It returns `sReady`=1 in the same cycle with `sResp`=2'b11 (decode error) and `sRData` all ones, whatever `cReady` is.
- R6: `cWrite`, `cBe` and `cWData` equal `sWrite`, `sBe` and `sWData` unchanged.
- R7: A control write to word 0 loads the base register from data bits 31:16. A write to word k (1..4) loads BDF register 2(k-1) from data bits 15:0 and BDF register 2k-1 from bits 31:16. The new value is used from the next clock edge.
- R8: After reset, the base register and all BDF registers are zero. Control reads return word 0 as {base, 16'h0000} and word k as {BDF 2k-1, BDF 2(k-1)}.
- R9: Control writes to words 5..15 change no register, and reads of those words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control-port write strobe |
| ctlAddr | input | CTL_AW | Control-port word address |
| ctlWrData | input | 32 | Control-port write data |
| ctlRdData | output | 32 | Control-port read data (combinational) |
| sReq | input | 1 | Slave access request |
| sAddr | input | 32 | Slave byte address |
| sWrite | input | 1 | Slave access is a write |
| sBe | input | DATA_W/8 | Slave byte enables |
| sWData | input | DATA_W | Slave write data |
| sReady | output | 1 | Slave access completes |
| sRData | output | DATA_W | Slave read data |
| sResp | output | 2 | Response: 00 okay, 11 decode error |
| cReq | output | 1 | Configuration request to the core |
| cAddr | output | 32 | Translated core-side address |
| cType1 | output | 1 | 1 selects a type 1 request, 0 a type 0 request |
| cWrite | output | 1 | Core access is a write |
| cBe | output | DATA_W/8 | Core byte enables |
| cWData | output | DATA_W | Core write data |
| cReady | input | 1 | Core access completes |
| cRData | input | DATA_W | Core read data |

## Verification
A corrupted BDF or base register shows up one cycle after the control write that should have loaded it. It appears as a wrong upper half of `cAddr`, or as a hit/miss decision flipped on the next access to the window, and the control-port readback shows it at once. A wrong region select or type decode shows up in the same cycle as the access, because the address path is purely combinational. The bench therefore checks each region with a different register pattern, so a swapped index changes the observed address.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int ADDR_W    = 32;
  localparam int BDF_W     = 16;
  localparam int NUM_BDF   = 8;
  localparam int REGION_W  = $clog2(NUM_BDF);
  localparam int WIN_W     = 16;
  localparam int REGION_LSB = WIN_W - 1 - REGION_W;
  localparam int CTL_DW    = 2 * BDF_W;
  localparam int NUM_PAIRS = NUM_BDF / 2;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_DECERR = 2'b11
  } resp_e;

  // strobes from the decode control to the datapath
  typedef struct packed {
    logic                hit;
    logic                type1;
    logic [REGION_W-1:0] region;
  } sel_t;
endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int CTL_AW = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctlWrEn,
  input  logic [CTL_AW-1:0]          ctlAddr,
  input  logic [CTL_DW-1:0]          ctlWrData,
  output logic [CTL_DW-1:0]          ctlRdData,
  output logic [ADDR_W-WIN_W-1:0]    winBase,
  output logic [NUM_BDF*BDF_W-1:0]   bdfFlat
);
  localparam int BASE_W = ADDR_W - WIN_W;

  logic [BASE_W-1:0] baseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
    end else if (ctlWrEn && ctlAddr == '0) begin
      baseQ <= ctlWrData[CTL_DW-1 -: BASE_W];
    end
  end

  assign winBase = baseQ;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [CTL_DW-1:0] pairQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pairQ <= '0;
      end else if (ctlWrEn && ctlAddr == CTL_AW'(p + 1)) begin
        pairQ <= ctlWrData;
      end
    end
    assign bdfFlat[p*CTL_DW +: CTL_DW] = pairQ;
  end

  always_comb begin
    ctlRdData = '0;
    if (ctlAddr == '0) begin
      ctlRdData = {baseQ, {(CTL_DW-BASE_W){1'b0}}};
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (ctlAddr == CTL_AW'(p + 1)) begin
        ctlRdData = bdfFlat[p*CTL_DW +: CTL_DW];
      end
    end
  end
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
(
  input  logic [ADDR_W-1:0]       sAddr,
  input  logic [ADDR_W-WIN_W-1:0] winBase,
  output sel_t                    sel
);
  logic baseMatch;
  logic lowerHalf;

  always_comb begin
    baseMatch  = (sAddr[ADDR_W-1:WIN_W] == winBase);
    lowerHalf  = !sAddr[WIN_W-1];
    sel.hit    = baseMatch && lowerHalf;
    sel.region = sAddr[WIN_W-2 -: REGION_W];
    sel.type1  = (sAddr[WIN_W-1:REGION_LSB] != '0);
  end
endmodule

// File: rtl/cfgwin_dp.sv
module cfgwin_dp
  import cfgwin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  sel_t                     sel,
  input  logic [NUM_BDF*BDF_W-1:0] bdfFlat,
  input  logic                     sReq,
  input  logic [ADDR_W-1:0]        sAddr,
  input  logic                     sWrite,
  input  logic [DATA_W/8-1:0]      sBe,
  input  logic [DATA_W-1:0]        sWData,
  output logic                     sReady,
  output logic [DATA_W-1:0]        sRData,
  output logic [1:0]               sResp,
  output logic                     cReq,
  output logic [ADDR_W-1:0]        cAddr,
  output logic                     cType1,
  output logic                     cWrite,
  output logic [DATA_W/8-1:0]      cBe,
  output logic [DATA_W-1:0]        cWData,
  input  logic                     cReady,
  input  logic [DATA_W-1:0]        cRData
);
  logic [BDF_W-1:0] bdfSel;
  resp_e            respVal;

  always_comb begin
    bdfSel = bdfFlat[sel.region*BDF_W +: BDF_W];
    cAddr  = {bdfSel, {(WIN_W-REGION_LSB){1'b0}}, sAddr[REGION_LSB-1:2], 2'b00};
    cType1 = sel.type1;
    cReq   = sReq && sel.hit;
    cWrite = sWrite;
    cBe    = sBe;
    cWData = sWData;
    sReady = sel.hit ? cReady : sReq;
    sRData = sel.hit ? cRData : '1;
    respVal = (sReq && !sel.hit) ? RESP_DECERR : RESP_OKAY;
    sResp  = respVal;
  end
endmodule

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate
  import cfgwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTL_AW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlWrEn,
  input  logic [CTL_AW-1:0]    ctlAddr,
  input  logic [31:0]          ctlWrData,
  output logic [31:0]          ctlRdData,
  input  logic                 sReq,
  input  logic [31:0]          sAddr,
  input  logic                 sWrite,
  input  logic [DATA_W/8-1:0]  sBe,
  input  logic [DATA_W-1:0]    sWData,
  output logic                 sReady,
  output logic [DATA_W-1:0]    sRData,
  output logic [1:0]           sResp,
  output logic                 cReq,
  output logic [31:0]          cAddr,
  output logic                 cType1,
  output logic                 cWrite,
  output logic [DATA_W/8-1:0]  cBe,
  output logic [DATA_W-1:0]    cWData,
  input  logic                 cReady,
  input  logic [DATA_W-1:0]    cRData
);
  logic [ADDR_W-WIN_W-1:0]  winBase;
  logic [NUM_BDF*BDF_W-1:0] bdfFlat;
  sel_t                     sel;

  cfgwin_regs #(.CTL_AW(CTL_AW)) regs_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWrEn   (ctlWrEn),
    .ctlAddr   (ctlAddr),
    .ctlWrData (ctlWrData),
    .ctlRdData (ctlRdData),
    .winBase   (winBase),
    .bdfFlat   (bdfFlat)
  );

  cfgwin_decode decode_i (
    .sAddr   (sAddr),
    .winBase (winBase),
    .sel     (sel)
  );

  cfgwin_dp #(.DATA_W(DATA_W)) dp_i (
    .sel     (sel),
    .bdfFlat (bdfFlat),
    .sReq    (sReq),
    .sAddr   (sAddr),
    .sWrite  (sWrite),
    .sBe     (sBe),
    .sWData  (sWData),
    .sReady  (sReady),
    .sRData  (sRData),
    .sResp   (sResp),
    .cReq    (cReq),
    .cAddr   (cAddr),
    .cType1  (cType1),
    .cWrite  (cWrite),
    .cBe     (cBe),
    .cWData  (cWData),
    .cReady  (cReady),
    .cRData  (cRData)
  );
endmodule

// File: rtl/cfgwin_xlate_chk.sv
module cfgwin_xlate_chk #(
  parameter int DATA_W = 32,
  parameter int CTL_AW = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                ctlWrEn,
  input logic [CTL_AW-1:0]   ctlAddr,
  input logic [31:0]         ctlWrData,
  input logic [31:0]         ctlRdData,
  input logic                sReq,
  input logic [31:0]         sAddr,
  input logic                sWrite,
  input logic [DATA_W/8-1:0] sBe,
  input logic [DATA_W-1:0]   sWData,
  input logic                sReady,
  input logic [DATA_W-1:0]   sRData,
  input logic [1:0]          sResp,
  input logic                cReq,
  input logic [31:0]         cAddr,
  input logic                cType1,
  input logic                cWrite,
  input logic [DATA_W/8-1:0] cBe,
  input logic [DATA_W-1:0]   cWData,
  input logic                cReady,
  input logic [DATA_W-1:0]   cRData
);
  AST_ADDR_ZERO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    cReq |-> (cAddr[15:12] == 4'h0 && cAddr[1:0] == 2'b00)); // R1
  AST_ADDR_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    cReq |-> cAddr[11:2] == sAddr[11:2]); // R1
  AST_TYPE_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    cReq |-> (cType1 == (sAddr[15:12] != 4'h0))); // R3
  AST_UPPER_HALF_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    sAddr[15] |-> !cReq); // R5
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !sReq |-> !cReq); // R4
  AST_MISS_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    (sReq && !cReq) |-> (sReady && sResp == 2'b11)); // R5
  AST_HIT_READY: assert property (@(posedge clk) disable iff (!rstN)
    cReq |-> (sReady == cReady && sResp == 2'b00)); // R4
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (cBe == sBe && cWData == sWData && cWrite == sWrite)); // R6
endmodule

bind cfgwin_xlate cfgwin_xlate_chk #(.DATA_W(DATA_W), .CTL_AW(CTL_AW)) chk_i (.*);

// File: tb/cfgwin_xlate_tb_top.sv
module cfgwin_xlate_tb_top;
  localparam int DATA_W = 32;
  localparam int CTL_AW = 4;
  localparam int NVEC   = 12;

  // bit 32: expected hit, bits 31:0: slave address
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 32'h4000_0004}, {1'b1, 32'h4000_1FFC}, {1'b1, 32'h4000_2100},
    {1'b1, 32'h4000_3ABC}, {1'b1, 32'h4000_4008}, {1'b1, 32'h4000_5010},
    {1'b1, 32'h4000_6FF0}, {1'b1, 32'h4000_7004}, {1'b0, 32'h4000_8000},
    {1'b0, 32'h4001_0000}, {1'b0, 32'h3FFF_0000}, {1'b0, 32'h4000_FFFC}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrEn = 1'b0;
  logic [CTL_AW-1:0] ctlAddr = '0;
  logic [31:0] ctlWrData = '0;
  logic [31:0] ctlRdData;
  logic sReq = 1'b0;
  logic [31:0] sAddr = '0;
  logic sWrite = 1'b0;
  logic [DATA_W/8-1:0] sBe = '0;
  logic [DATA_W-1:0] sWData = '0;
  logic sReady;
  logic [DATA_W-1:0] sRData;
  logic [1:0] sResp;
  logic cReq;
  logic [31:0] cAddr;
  logic cType1;
  logic cWrite;
  logic [DATA_W/8-1:0] cBe;
  logic [DATA_W-1:0] cWData;
  logic cReady = 1'b0;
  logic [DATA_W-1:0] cRData = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] bdfExp [8];

  always #10 clk = ~clk;

  cfgwin_xlate #(.DATA_W(DATA_W), .CTL_AW(CTL_AW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [CTL_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlAddr = a; ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  function automatic logic [31:0] expAddr(input logic [31:0] a);
    return {bdfExp[a[14:12]], 4'h0, a[11:2], 2'b00};
  endfunction

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset readback and base zero window
    for (int w = 0; w < 5; w++) begin
      ctlAddr = CTL_AW'(w); #1;
      chk($sformatf("R8 reset word %0d", w), ctlRdData, 32'h0);
    end
    sReq = 1'b1; sAddr = 32'h0000_0004; cReady = 1'b1; #1;
    chk("R8 reset hit at base 0", {31'h0, cReq}, 32'h1);
    chk("R8 reset address", cAddr, 32'h0000_0004);
    sReq = 1'b0;

    // R7: program base and registers
    ctlWrite(4'd0, 32'h4000_1234);
    ctlWrite(4'd1, 32'h1122_0008);
    ctlWrite(4'd2, 32'h3344_5566);
    ctlWrite(4'd3, 32'h7788_99AA);
    ctlWrite(4'd4, 32'hBBCC_DDEE);
    bdfExp = '{16'h0008, 16'h1122, 16'h5566, 16'h3344,
               16'h99AA, 16'h7788, 16'hDDEE, 16'hBBCC};
    ctlAddr = 4'd0; #1;
    chk("R7 base readback", ctlRdData, 32'h4000_0000);
    ctlAddr = 4'd3; #1;
    chk("R7 pair readback", ctlRdData, 32'h7788_99AA);

    // vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      sReq = 1'b1; sAddr = VEC[i][31:0]; sWrite = i[0];
      sBe = 4'(i + 1); sWData = 32'hA5A5_0000 + i;
      cReady = 1'b1; cRData = 32'hC0DE_0000 + i;
      #5;
      chk($sformatf("R4 R5 req vec %0d", i), {31'h0, cReq}, {31'h0, VEC[i][32]});
      chk($sformatf("R4 R5 ready vec %0d", i), {31'h0, sReady}, 32'h1);
      chk($sformatf("R6 be vec %0d", i), {28'h0, cBe}, {28'h0, sBe});
      chk($sformatf("R6 wdata vec %0d", i), cWData, 32'hA5A5_0000 + i);
      if (VEC[i][32]) begin
        chk($sformatf("R1 R2 addr vec %0d", i), cAddr, expAddr(VEC[i][31:0]));
        chk($sformatf("R3 type vec %0d", i), {31'h0, cType1},
            {31'h0, (VEC[i][14:12] != 3'd0)});
        chk($sformatf("R4 resp vec %0d", i), {30'h0, sResp}, 32'h0);
        chk($sformatf("R4 rdata vec %0d", i), sRData, 32'hC0DE_0000 + i);
      end else begin
        chk($sformatf("R5 resp vec %0d", i), {30'h0, sResp}, 32'h3);
        chk($sformatf("R5 rdata vec %0d", i), sRData, 32'hFFFF_FFFF);
      end
    end

    // R4: hit waits on core ready; idle gives no request
    @(negedge clk);
    sReq = 1'b1; sAddr = 32'h4000_2000; cReady = 1'b0; #5;
    chk("R4 hit stalls", {31'h0, sReady}, 32'h0);
    chk("R4 hit request", {31'h0, cReq}, 32'h1);
    sReq = 1'b0; #1;
    chk("R4 idle no request", {31'h0, cReq}, 32'h0);
    chk("R4 idle resp okay", {30'h0, sResp}, 32'h0);

    // R5: miss completes even when the core is not ready
    sReq = 1'b1; sAddr = 32'h4000_9000; #1;
    chk("R5 miss ready", {31'h0, sReady}, 32'h1);
    chk("R5 miss no request", {31'h0, cReq}, 32'h0);
    sReq = 1'b0;

    // R9: writes to unused words are ignored
    ctlWrite(4'd6, 32'hFFFF_FFFF);
    ctlWrite(4'd15, 32'hFFFF_FFFF);
    ctlAddr = 4'd6; #1;
    chk("R9 unused word reads zero", ctlRdData, 32'h0);
    ctlAddr = 4'd0; #1;
    chk("R9 base unchanged", ctlRdData, 32'h4000_0000);
    for (int w = 1; w < 5; w++) begin
      ctlAddr = CTL_AW'(w); #1;
      chk($sformatf("R9 word %0d unchanged", w), ctlRdData,
          {bdfExp[2*w-1], bdfExp[2*w-2]});
    end

    // R7: rewrite register 0, used from the next edge
    ctlWrite(4'd1, 32'h1122_ABCD);
    bdfExp[0] = 16'hABCD;
    sReq = 1'b1; sAddr = 32'h4000_0010; cReady = 1'b1; #1;
    chk("R7 new value used", cAddr, 32'hABCD_0010);
    chk("R3 region 0 type 0", {31'h0, cType1}, 32'h0);
    // R7: move the window, old base now misses
    ctlWrite(4'd0, 32'h8000_0000);
    #1;
    chk("R7 old base misses", {31'h0, cReq}, 32'h0);
    sAddr = 32'h8000_1004; #1;
    chk("R7 new base hits", cAddr, 32'h1122_0004);
    sReq = 1'b0;

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule